// File: doc/BRIEF.md
# Power Management Interval Timer

This block is a free-running, read-only interval timer for power management software. It runs in the 14.31818 MHz crystal clock domain. An internal prescaler divides that clock by four, which gives the 3.579545 MHz advance rate. The count advances only while the system reports the working state and the master count enable is high. While the oscillator-running indicator is low, both the prescaler phase and the count hold, so counting resumes from the held value when the oscillator returns.

A run-time width select chooses between a narrow count (24 bits by default) and a wide count (32 bits by default). In narrow mode only the low field advances and wraps, and the readback shows zero above it. A one-cycle status pulse marks every advance that flips the most significant active bit. Software can use that pulse as a half-period rollover event.

Top module: `pwr_mgmt_timer`

## Requirements
- R1: While `rst_n` is low, `tmr_value` is zero, `msb_toggle` is zero and the prescaler phase returns to its first step.
- R2: With `osc_run`, `in_s0` and `cnt_en` all high, the count advances by exactly one on every PRESCALE-th clock cycle and holds on all the others.
- R3: While `in_s0` is low, the count does not advance, but the prescaler keeps its rhythm.
- R4: While `cnt_en` is low, the count does not advance, but the prescaler keeps its rhythm.
- R5: While `osc_run` is low, both the count and the prescaler phase hold. When `osc_run` returns high, counting continues from the held values without restarting.
- R6: With `wide_mode` = 0, only bits NARROW_W-1..0 advance, wrapping from all ones to zero. Bits CNT_W-1..NARROW_W of the stored count are left untouched and read back as zero.
- R7: With `wide_mode` = 1, the full CNT_W-bit count advances and wraps from all ones to zero.
- R8: `msb_toggle` is high for one cycle, in the same cycle that the new count appears, exactly when an advance changed the active top bit. That bit is bit NARROW_W-1 in narrow mode and bit CNT_W-1 in wide mode.
- R9: `wide_mode` acts on the readback mask combinationally, in the same cycle that it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 14.31818 MHz crystal-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Master enable for counting |
| wide_mode | input | 1 | 1 selects the CNT_W-bit count, 0 selects the NARROW_W-bit count |
| in_s0 | input | 1 | High while the system is in the working state |
| osc_run | input | 1 | High while the crystal oscillator is running |
| tmr_value | output | CNT_W | Count readback, with the upper field zeroed in narrow mode |
| msb_toggle | output | 1 | One-cycle pulse when an advance flips the active top bit |

## Verification
A wrong prescaler phase shows up at `tmr_value` within at most PRESCALE cycles, as an advance that comes early or late. A wrong count shows up on the very next read. A bad carry into the upper field only appears after the narrow field wraps and the mode is switched to wide. It is caught on the first wide-mode read after that switch. A missing or extra toggle pulse shows up in the cycle the top bit flips, so the bench compares every cycle against an arithmetic model. It sweeps whole wrap periods of a 10-bit count with a 6-bit narrow field.

// File: rtl/pwr_mgmt_timer_pkg.sv
package pwr_mgmt_timer_pkg;

  function automatic logic [31:0] width_mask(input int w);
    width_mask = (32'h1 << w) - 32'h1;
  endfunction

  function automatic logic [31:0] step_count(input logic [31:0] c, input logic wide,
                                             input int cw, input int nw);
    logic [31:0] fm;
    logic [31:0] nm;
    fm = width_mask(cw);
    nm = width_mask(nw);
    if (wide) step_count = (c + 32'h1) & fm;
    else      step_count = ((c & ~nm) | ((c + 32'h1) & nm)) & fm;
  endfunction

  function automatic logic top_bit(input logic [31:0] c, input logic wide,
                                   input int cw, input int nw);
    top_bit = wide ? c[cw-1] : c[nw-1];
  endfunction

  function automatic logic [31:0] read_view(input logic [31:0] c, input logic wide,
                                            input int cw, input int nw);
    read_view = c & (wide ? width_mask(cw) : width_mask(nw));
  endfunction

endpackage

// File: rtl/pwr_mgmt_prescaler.sv
module pwr_mgmt_prescaler #(
  parameter int PRESCALE = 4,
  localparam int PH_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  logic [PH_W-1:0] phase_q;
  localparam logic [PH_W-1:0] LAST = PH_W'(PRESCALE - 1);

  generate
    if (PRESCALE > 1) begin : g_div
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    phase_q <= '0;
        else if (run)  phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
      end
      assign tick = run && (phase_q == LAST);
    end else begin : g_pass
      assign phase_q = '0;
      assign tick    = run;
    end
  endgenerate
endmodule

// File: rtl/pwr_mgmt_counter.sv
module pwr_mgmt_counter
  import pwr_mgmt_timer_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             wide,
  output logic [CNT_W-1:0] count_q,
  output logic             flip_q
);
  logic [CNT_W-1:0] count_d;
  logic             flip_d;

  always_comb begin
    count_d = CNT_W'(step_count(32'(count_q), wide, CNT_W, NARROW_W));
    flip_d  = inc && (top_bit(32'(count_d), wide, CNT_W, NARROW_W) !=
                      top_bit(32'(count_q), wide, CNT_W, NARROW_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      flip_q  <= 1'b0;
    end else begin
      flip_q <= flip_d;
      if (inc) count_q <= count_d;
    end
  end
endmodule

// File: rtl/pwr_mgmt_timer.sv
module pwr_mgmt_timer
  import pwr_mgmt_timer_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 24,
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             wide_mode,
  input  logic             in_s0,
  input  logic             osc_run,
  output logic [CNT_W-1:0] tmr_value,
  output logic             msb_toggle
);
  logic             tick_w;
  logic             inc_w;
  logic [CNT_W-1:0] count_w;

  pwr_mgmt_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (osc_run),
    .tick (tick_w)
  );

  assign inc_w = tick_w && in_s0 && cnt_en;

  pwr_mgmt_counter #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (inc_w),
    .wide   (wide_mode),
    .count_q(count_w),
    .flip_q (msb_toggle)
  );

  assign tmr_value = CNT_W'(read_view(32'(count_w), wide_mode, CNT_W, NARROW_W));
endmodule

// File: rtl/pwr_mgmt_timer_chk.sv
module pwr_mgmt_timer_chk #(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 24,
  parameter int PRESCALE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             wide_mode,
  input logic             in_s0,
  input logic             osc_run,
  input logic [CNT_W-1:0] tmr_value,
  input logic             msb_toggle,
  input logic             tick,
  input logic             inc
);
  // R6
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_mode |-> (tmr_value >> NARROW_W) == '0);

  // R3
  idle_state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_s0 && wide_mode) |=> (!wide_mode || $stable(tmr_value)));

  // R4
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && wide_mode) |=> (!wide_mode || $stable(tmr_value)));

  // R5
  osc_stop_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run |-> !tick);

  // R8
  toggle_needs_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msb_toggle |-> $past(inc));

  // R2
  advance_changes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && wide_mode) |=> (!wide_mode || tmr_value != $past(tmr_value)));

  generate
    if (PRESCALE > 1) begin : g_spacing
      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

bind pwr_mgmt_timer pwr_mgmt_timer_chk #(
  .CNT_W(CNT_W), .NARROW_W(NARROW_W), .PRESCALE(PRESCALE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wide_mode(wide_mode),
  .in_s0(in_s0), .osc_run(osc_run), .tmr_value(tmr_value),
  .msb_toggle(msb_toggle), .tick(tick_w), .inc(inc_w)
);

// File: tb/pwr_mgmt_timer_tb.sv
module pwr_mgmt_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;
  localparam int NW = 6;
  localparam int PS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cnt_en = 1'b0, wide_mode = 1'b0, in_s0 = 1'b0, osc_run = 1'b0;
  logic [CW-1:0] tmr_value;
  logic          msb_toggle;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [CW-1:0] m_cnt = '0;
  int            m_pc = 0;
  bit            m_pulse = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mgmt_timer #(.CNT_W(CW), .NARROW_W(NW), .PRESCALE(PS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wide_mode(wide_mode),
    .in_s0(in_s0), .osc_run(osc_run), .tmr_value(tmr_value), .msb_toggle(msb_toggle)
  );

  function automatic logic [CW-1:0] expect_read(input logic [CW-1:0] c, input bit w);
    return w ? c : (c % (1 << NW));
  endfunction

  task automatic check(input string tag, input logic [CW-1:0] got_v, exp_v,
                       input bit got_p, exp_p);
    checks++;
    if (got_v !== exp_v || got_p !== exp_p) begin
      errors++;
      $display("FAIL %s t=%0t value=%0d/%0d expected %0d/%0d", tag, $time,
               got_v, got_p, exp_v, exp_p);
    end
  endtask

  // Starts and ends at a falling edge.
  task automatic step(input bit s0, en, run, w, input string tag);
    bit      t;
    int      lo;
    int      old_top;
    int      new_top;
    in_s0 = s0; cnt_en = en; osc_run = run; wide_mode = w;
    @(posedge clk);
    t = run && (m_pc == PS - 1);
    if (run) m_pc = (m_pc + 1) % PS;
    m_pulse = 1'b0;
    if (t && s0 && en) begin
      old_top = w ? m_cnt[CW-1] : m_cnt[NW-1];
      if (w) m_cnt = CW'((int'(m_cnt) + 1) % (1 << CW));
      else begin
        lo    = (int'(m_cnt) % (1 << NW) + 1) % (1 << NW);
        m_cnt = CW'((int'(m_cnt) / (1 << NW)) * (1 << NW) + lo);
      end
      new_top = w ? m_cnt[CW-1] : m_cnt[NW-1];
      m_pulse = (old_top != new_top);
    end
    @(negedge clk);
    check(tag, tmr_value, expect_read(m_cnt, w), msb_toggle, m_pulse);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", tmr_value, '0, msb_toggle, 1'b0);
    osc_run = 1'b1; in_s0 = 1'b1; cnt_en = 1'b1; wide_mode = 1'b1;
    @(negedge clk);
    check("R1 held", tmr_value, '0, msb_toggle, 1'b0);
    rst_n = 1'b1;

    // R2 R7 R8: full wide sweep past wrap
    for (int i = 0; i < (PS << CW) + 40; i++) step(1, 1, 1, 1, "R2 R7 R8");
    // R6 R8: narrow sweep over several wraps
    for (int i = 0; i < (PS << NW) * 3 + 10; i++) step(1, 1, 1, 0, "R6 R8");
    // upper field untouched by narrow wraps, visible in wide
    step(1, 1, 1, 1, "R6 upper");
    // R3: working-state gating
    for (int i = 0; i < 300; i++) step((i % 7) < 3, 1, 1, i[6], "R3");
    // R4: enable gating
    for (int i = 0; i < 300; i++) step(1, (i % 5) < 2, 1, i[5], "R4");
    // R5: oscillator stops and resumes
    for (int i = 0; i < 300; i++) step(1, 1, (i % 11) > 4, i[7], "R5");
    for (int i = 0; i < 20; i++) step(1, 1, 0, 1, "R5 stop");
    for (int i = 0; i < 20; i++) step(1, 1, 1, 1, "R5 resume");
    // R9: mode switch acts on readback in the same cycle
    for (int i = 0; i < 8; i++) begin
      wide_mode = ~wide_mode;
      #1;
      check("R9", tmr_value, expect_read(m_cnt, wide_mode), msb_toggle, m_pulse);
      step(1, 1, 1, wide_mode, "R9 step");
    end
    // mixed pattern
    for (int i = 0; i < 2000; i++)
      step((i % 13) != 0, (i % 17) != 0, (i % 19) != 0, (i / 97) % 2 == 0, "R2 R6 R8");

    // R1: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    m_cnt = '0; m_pc = 0; m_pulse = 1'b0;
    check("R1 async", tmr_value, '0, msb_toggle, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 50; i++) step(1, 1, 1, 1, "R1 R2 after reset");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule